// File: doc/BRIEF.md
# Register-Programmed SPI Shift Engine

This block is an SPI master run entirely through a small 32-bit register bus. Software loads a word into the transmit register and picks a clock divider. It then writes one command word that names the chip selects, the number of bits (1 to 32) and whether the frame ends with this command. The engine drives the serial clock in mode 0: the clock idles low, MOSI changes while the clock is low, and MISO is sampled on each rising edge. Received bits collect in a receive register. Bit 31 of the command register stays set while the shift runs, so software polls that bit to learn when the shift is done.

A frame longer than 32 bits is built from several commands sent back to back. Every command but the last leaves the terminate flag clear, so the chip select stays low between them. While the register interface is switched off, a pin-control register drives the three chip selects, the clock and MOSI directly.

The bus is a plain register port: a single-cycle write strobe and a combinational read of the addressed register. It has no valid/ready handshake. A write is never stalled. A shift command that arrives while a shift is running is dropped, and software avoids this by polling the busy bit.

Top module: `spi_shift_engine`

## Requirements
- R1: Out of reset, registers read as follows: function select (offset 0x00) reads 0, shift control (0x14) reads 0, pin control (0x08) reads 0x0007_0000. The pins are cs_n = 3'b111, sclk = 0 and mosi = 0.
- R2: While bit 0 of function select is 0, shift commands have no effect and busy stays 0. The pins then follow pin control: cs_n from bits 18:16, sclk from bit 8, mosi from bit 0.
- R3: Control bits 5:0 hold divider D, and one half SCLK period lasts D+1 clocks. After an accepted N-bit command, busy (shift-control bit 31) is 1 for (2N+1)(D+1) clocks, starting the cycle after the write. SCLK is high during odd half periods 1, 3, …, 2N−1 and low otherwise.
- R4: MOSI carries data-out bit N−1 first and then the lower bits, most significant first. It changes only while SCLK is low, and it holds each bit for both half periods around that bit's rising edge.
- R5: MISO is sampled on each rising SCLK edge and shifted into data-in (0x18) from bit 0. After N bits, data-in bits N−1..0 hold the received bits with the first bit highest, and all higher bits are 0.
- R6: Shift-control bits 30:28 pick chip selects 2..0. The picked lines go low in the cycle after the command is accepted, half a period before the first rising edge. With bit 26 (terminate) set, they return high half a period after the last falling edge. With it clear, they stay low until a later command.
- R7: A read of shift control returns the live busy bit in bit 31 and the accepted select, terminate and count fields in their own positions. All other bits read 0.
- R8: A shift-control write is ignored while busy is 1, including a write in the very cycle in which the shift completes. The write leaves the stored fields and the pins unchanged.
- R9: A command with count 0 starts nothing: busy stays 0 and SCLK does not toggle. A count above 32 shifts 32 bits.
- R10: The divider and data-out are captured when a command is accepted. Writes to the control or data-out register during a shift do not alter that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 3 | Active-low chip selects |

## Verification
Two events can fall in the same cycle: the last tail cycle of a shift, in which busy falls, and a fresh shift-control write from software. The bench follows its own reference model to the last busy cycle and asserts a new start command at exactly that edge. It then checks that busy stays 0 and that the stored fields and the pins still show the finished command. The same model is compared with sclk, mosi and cs_n on every clock, which also catches a start that was accepted one cycle early.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned NUM_CS = 3;
  localparam int unsigned DIV_W  = 6;
  localparam int unsigned CNT_W  = 6;

  localparam logic [ADDR_W-1:0] ADR_FSEL  = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_PIN   = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_DOUT  = 5'h10;
  localparam logic [ADDR_W-1:0] ADR_SHIFT = 5'h14;
  localparam logic [ADDR_W-1:0] ADR_DIN   = 5'h18;

  localparam int unsigned SH_GO_BIT   = 31;
  localparam int unsigned SH_SEL_LSB  = 28;
  localparam int unsigned SH_TERM_BIT = 26;
  localparam int unsigned PIN_CS_LSB  = 16;
  localparam int unsigned PIN_SCLK    = 8;
  localparam int unsigned PIN_MOSI    = 0;
  localparam logic [BUS_W-1:0] PIN_RST = 32'h0007_0000;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_TAIL} eng_state_t;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NCS    = 3,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NCS-1:0]    start_sel,
  input  logic              start_term,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic [DATA_W-1:0] start_data,
  input  logic [DIV_W-1:0]  start_div,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [NCS-1:0]    cs_act,
  output logic [DATA_W-1:0] rx_data
);
  localparam int unsigned SH_W = CNT_W + 1;

  eng_state_t        st_q;
  logic [DIV_W-1:0]  div_q;
  logic              term_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic              sclk_q;
  logic [NCS-1:0]    cs_q;
  logic              tick;
  logic              run;
  logic [SH_W-1:0]   align;

  assign run   = (st_q != ST_IDLE);
  assign align = SH_W'(DATA_W) - {1'b0, start_cnt};

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .limit (div_q),
    .tick  (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      div_q  <= '0;
      term_q <= 1'b0;
      left_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_LOW;
          div_q  <= start_div;
          term_q <= start_term;
          cs_q   <= start_sel;
          left_q <= start_cnt;
          tx_q   <= start_data << align;
          rx_q   <= '0;
          sclk_q <= 1'b0;
        end
        ST_LOW: if (tick) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[DATA_W-2:0], miso};
          st_q   <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk_q <= 1'b0;
          if (left_q == CNT_W'(1)) begin
            st_q <= ST_TAIL;
          end else begin
            left_q <= left_q - 1'b1;
            tx_q   <= tx_q << 1;
            st_q   <= ST_LOW;
          end
        end
        ST_TAIL: if (tick) begin
          if (term_q) cs_q <= '0;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = run;
  assign sclk    = sclk_q;
  assign mosi    = tx_q[DATA_W-1];
  assign cs_act  = cs_q;
  assign rx_data = rx_q;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(BUS_W);

  logic              fsel_q;
  logic [DIV_W-1:0]  div_q;
  logic [BUS_W-1:0]  pin_q;
  logic [BUS_W-1:0]  dout_q;
  logic [NUM_CS-1:0] sel_q;
  logic              term_q;
  logic [CNT_W-1:0]  cnt_q;

  logic              sh_wr, sh_take, start;
  logic [CNT_W-1:0]  cnt_raw, cnt_eff;
  logic              core_busy, core_sclk, core_mosi;
  logic [NUM_CS-1:0] core_cs;
  logic [BUS_W-1:0]  core_rx;

  assign cnt_raw = bus_wdata[CNT_W-1:0];
  assign cnt_eff = (cnt_raw > MAX_CNT) ? MAX_CNT : cnt_raw;
  assign sh_wr   = bus_wr && (bus_addr == ADR_SHIFT);
  assign sh_take = sh_wr && fsel_q && !core_busy;
  assign start   = sh_take && bus_wdata[SH_GO_BIT] && (cnt_eff != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= 1'b0;
      div_q  <= '0;
      pin_q  <= PIN_RST;
      dout_q <= '0;
      sel_q  <= '0;
      term_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (bus_wr && bus_addr == ADR_FSEL) fsel_q <= bus_wdata[0];
      if (bus_wr && bus_addr == ADR_CTRL) div_q  <= bus_wdata[DIV_W-1:0];
      if (bus_wr && bus_addr == ADR_PIN)  pin_q  <= bus_wdata;
      if (bus_wr && bus_addr == ADR_DOUT) dout_q <= bus_wdata;
      if (sh_take) begin
        sel_q  <= bus_wdata[SH_SEL_LSB +: NUM_CS];
        term_q <= bus_wdata[SH_TERM_BIT];
        cnt_q  <= cnt_raw;
      end
    end
  end

  spi_shift_core #(
    .DATA_W (BUS_W),
    .NCS    (NUM_CS),
    .CNT_W  (CNT_W),
    .DIV_W  (DIV_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_sel  (bus_wdata[SH_SEL_LSB +: NUM_CS]),
    .start_term (bus_wdata[SH_TERM_BIT]),
    .start_cnt  (cnt_eff),
    .start_data (dout_q),
    .start_div  (div_q),
    .miso       (miso),
    .busy       (core_busy),
    .sclk       (core_sclk),
    .mosi       (core_mosi),
    .cs_act     (core_cs),
    .rx_data    (core_rx)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = fsel_q ? ~core_cs[i] : pin_q[PIN_CS_LSB + i];
  end
  assign sclk = fsel_q ? core_sclk : pin_q[PIN_SCLK];
  assign mosi = fsel_q ? core_mosi : pin_q[PIN_MOSI];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_FSEL:  bus_rdata[0] = fsel_q;
      ADR_CTRL:  bus_rdata[DIV_W-1:0] = div_q;
      ADR_PIN:   bus_rdata = pin_q;
      ADR_DOUT:  bus_rdata = dout_q;
      ADR_SHIFT: begin
        bus_rdata[SH_GO_BIT]              = core_busy;
        bus_rdata[SH_SEL_LSB +: NUM_CS]   = sel_q;
        bus_rdata[SH_TERM_BIT]            = term_q;
        bus_rdata[CNT_W-1:0]              = cnt_q;
      end
      ADR_DIN:   bus_rdata = core_rx;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk
  import spi_eng_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs_n,
  input logic              busy,
  input logic              en,
  input logic [CNT_W-1:0]  st_cnt
);
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !busy) |-> !sclk);

  p_cs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && busy && $past(busy)) |-> $stable(cs_n));

  p_mosi_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && sclk && $past(sclk)) |-> $stable(mosi));

  p_busy_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_SHIFT && busy) |=> $stable(st_cnt));

  p_zero_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_SHIFT && !busy && bus_wdata[CNT_W-1:0] == '0) |=> !busy);

  p_off_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy && bus_wr && bus_addr == ADR_SHIFT) |=> !busy);
endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .sclk      (sclk),
  .mosi      (mosi),
  .cs_n      (cs_n),
  .busy      (core_busy),
  .en        (fsel_q),
  .st_cnt    (cnt_q)
);

// File: tb/spi_shift_engine_test.sv
`timescale 1ns/1ps
module spi_shift_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso;
  logic [2:0]  cs_n;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  spi_shift_engine uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // reference model
  logic        m_busy = 0, m_en = 0, m_term = 0;
  logic [31:0] m_pin = 32'h0007_0000, m_dout = 0, m_data = 0, m_sw = 0;
  logic [5:0]  m_div = 0, m_cnt = 0;
  logic [2:0]  m_held = 0, m_sel = 0;
  int          m_t = 0, m_n = 1, m_h = 1;
  logic        pre_busy, pre_en;
  int          wn;

  initial miso = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_en = 0; m_pin = 32'h0007_0000; m_dout = 0; m_div = 0;
      m_cnt = 0; m_sel = 0; m_term = 0; m_held = 0; m_t = 0;
    end else begin
      pre_busy = m_busy;
      pre_en   = m_en;
      if (m_busy) begin
        m_t++;
        if (m_t == (2 * m_n + 1) * m_h) begin
          m_busy = 0;
          if (m_term) m_held = 0;
        end
      end
      if (bus_wr) begin
        case (bus_addr)
          5'h00: m_en = bus_wdata[0];
          5'h04: m_div = bus_wdata[5:0];
          5'h08: m_pin = bus_wdata;
          5'h10: m_dout = bus_wdata;
          5'h14: if (pre_en && !pre_busy) begin
            m_sel = bus_wdata[30:28]; m_term = bus_wdata[26]; m_cnt = bus_wdata[5:0];
            wn = (bus_wdata[5:0] > 32) ? 32 : int'(bus_wdata[5:0]);
            if (bus_wdata[31] && wn != 0) begin
              m_busy = 1; m_t = 0; m_n = wn; m_h = int'(m_div) + 1;
              m_data = m_dout; m_held = bus_wdata[30:28];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison and slave drive, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic es, em;
      logic [2:0] ec;
      int h, bi;
      h = m_t / m_h;
      if (!m_en) begin
        es = m_pin[8]; em = m_pin[0]; ec = m_pin[18:16];
        chk(sclk == es && mosi == em && cs_n == ec, "R2", "pin-control pins",
            {cs_n, sclk, mosi}, {ec, es, em});
      end else begin
        ec = ~m_held;
        es = m_busy && (h % 2 == 1) && (h < 2 * m_n);
        chk(cs_n == ec, "R6", "cs_n", cs_n, ec);
        chk(sclk == es, "R3", "sclk", sclk, es);
        if (m_busy) begin
          bi = h / 2;
          if (bi > m_n - 1) bi = m_n - 1;
          em = m_data[m_n - 1 - bi];
          chk(mosi == em, "R4", "mosi", mosi, em);
        end
      end
      if (m_busy) begin
        bi = (h + 1) / 2;
        if (bi > m_n - 1) bi = m_n - 1;
        miso = m_sw[m_n - 1 - bi];
      end else miso = 1'b0;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
  endtask

  function automatic logic [31:0] lowmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  function automatic logic [31:0] cmd(input logic [2:0] sel, input bit term, input int n);
    return {1'b1, sel, 1'b0, term, 20'h0, 6'(n)};
  endfunction

  initial begin
    logic [31:0] r;
    int total;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(5'h08, r); chk(r == 32'h0007_0000, "R1", "pin-control reset", r, 32'h0007_0000);
    rd(5'h00, r); chk(r == 0, "R1", "function-select reset", r, 0);
    rd(5'h14, r); chk(r == 0, "R1", "shift-control reset", r, 0);
    chk(cs_n == 3'b111 && sclk == 0 && mosi == 0, "R1", "reset pins", {cs_n, sclk, mosi}, 5'b11100);

    // R2 disabled: command ignored, pins from pin-control
    wr(5'h10, 32'hFF);
    wr(5'h14, cmd(3'b001, 1, 8));
    rd(5'h14, r); chk(r == 0, "R2", "ignored command readback", r, 0);
    wr(5'h08, 32'h0002_0101);
    repeat (3) @(negedge clk);
    chk(cs_n == 3'b010 && sclk && mosi, "R2", "driven pins", {cs_n, sclk, mosi}, 5'b01011);
    wr(5'h08, 32'h0007_0000);

    // basic 8-bit, D=0
    wr(5'h00, 1);
    wr(5'h04, 0);
    wr(5'h10, 32'h0000_00A5); m_sw = 32'h0000_003C;
    wr(5'h14, cmd(3'b001, 1, 8));
    rd(5'h14, r); chk(r[31] == 1, "R7", "live busy bit", r[31], 1);
    wait_idle();
    rd(5'h18, r); chk(r == 32'h3C, "R5", "rx 8 bits", r, 32'h3C);
    rd(5'h14, r); chk(r == 32'h1400_0008, "R7", "readback after done", r, 32'h1400_0008);
    chk(cs_n == 3'b111, "R6", "terminated cs", cs_n, 3'b111);

    // 32-bit held frame then 16-bit terminating, D=2
    wr(5'h04, 2);
    wr(5'h10, 32'hDEAD_BEEF); m_sw = 32'h8123_4567;
    wr(5'h14, cmd(3'b010, 0, 32));
    wait_idle();
    rd(5'h18, r); chk(r == 32'h8123_4567, "R5", "rx 32 bits", r, 32'h8123_4567);
    repeat (4) @(negedge clk);
    chk(cs_n == 3'b101, "R6", "cs held between commands", cs_n, 3'b101);
    wr(5'h10, 32'hFFFF_1234); m_sw = 32'hFFFF_9A0F;
    wr(5'h14, cmd(3'b010, 1, 16));
    wait_idle();
    rd(5'h18, r); chk(r == (32'hFFFF_9A0F & lowmask(16)), "R5", "rx 16 bits upper zero", r, 32'h9A0F);
    chk(cs_n == 3'b111, "R6", "released after terminate", cs_n, 3'b111);

    // R8 write while busy
    wr(5'h04, 3);
    wr(5'h10, 32'h0000_0081); m_sw = 32'h55;
    wr(5'h14, cmd(3'b100, 1, 8));
    wr(5'h14, cmd(3'b001, 0, 5));
    rd(5'h14, r); chk(r == 32'hC400_0008, "R8", "fields kept during busy", r, 32'hC400_0008);
    wait_idle();

    // R8 same-cycle: new command on the completion edge
    wr(5'h04, 1);
    wr(5'h10, 32'h0000_0009); m_sw = 32'h6;
    wr(5'h14, cmd(3'b001, 1, 4));
    total = (2 * 4 + 1) * 2;
    while (!(m_busy && m_t == total - 1)) @(negedge clk);
    bus_wr = 1; bus_addr = 5'h14; bus_wdata = cmd(3'b100, 0, 12);
    @(negedge clk);
    bus_wr = 0;
    rd(5'h14, r); chk(r == 32'h1400_0004, "R8", "completion-edge write ignored", r, 32'h1400_0004);
    chk(cs_n == 3'b111, "R8", "pins after ignored write", cs_n, 3'b111);

    // R9 count zero and count above 32
    wr(5'h14, cmd(3'b001, 0, 0));
    rd(5'h14, r); chk(r[31] == 0, "R9", "zero count not busy", r[31], 0);
    chk(sclk == 0, "R9", "zero count no sclk", sclk, 0);
    wr(5'h04, 0);
    wr(5'h10, 32'hC3C3_5AA5); m_sw = 32'h1357_9BDF;
    wr(5'h14, cmd(3'b001, 1, 40));
    wait_idle();
    rd(5'h18, r); chk(r == 32'h1357_9BDF, "R9", "count 40 shifts 32", r, 32'h1357_9BDF);

    // R10 divider and data captured at start
    wr(5'h04, 4);
    wr(5'h10, 32'h0000_B00B); m_sw = 32'h0000_7E81;
    wr(5'h14, cmd(3'b100, 1, 16));
    wr(5'h04, 0);
    wr(5'h10, 32'h0000_FFFF);
    wait_idle();
    rd(5'h18, r); chk(r == 32'h7E81, "R10", "rx with latched divider", r, 32'h7E81);

    // slowest divider, R3
    wr(5'h04, 63);
    wr(5'h10, 32'h2); m_sw = 32'h1;
    wr(5'h14, cmd(3'b010, 1, 2));
    wait_idle();
    rd(5'h18, r); chk(r == 32'h1, "R3", "rx at divider 63", r, 32'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog actual=%0d expected<%0d cycles", 150000, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule